// File: doc/BRIEF.md
# Two-Channel Chained Instruction-Fetch Breakpoint

This block sits beside a processor's instruction-fetch path and asks for a debug break before a chosen instruction runs. Two comparator channels each hold a compare address, an address don't-care mask and an optional address-space-ID filter. Channel 1 can also compare the fetched instruction word under a data mask and can hold off its break for a programmed number of hits.

The channels run in one of two modes. In independent mode, either channel's hit raises the break request on its own. In chained mode, a channel 0 hit only arms the unit. The arming happens when a matching instruction is reported on the commit port. After that, the next channel 1 hit raises the break and disarms the unit. Settings arrive through a plain register write port.

The fetch and commit ports are observe-only streams. Each carries a valid strobe and no ready, because the unit never stalls the processor: a beat is taken in every cycle its valid is high. The break request is combinational from the fetch beat it flags, so it is high in the same cycle as that beat.

Top module: `ifetch_break_unit`

## Requirements
- R1: After reset every channel is disabled, the mode is independent, both `ch_match` bits and `brk_req` stay 0 for any fetch, and `brk_status` reads 0.
- R2: A channel's address test passes when every address bit whose mask bit is 0 equals the compare address. A mask bit of 1 makes that address bit don't-care.
- R3: Address bit 0 is always compared, whatever the mask says. A channel programmed with an odd compare address therefore never matches an even fetch address.
- R4: When a channel's ASID enable (control bit 1) is set, a match also needs `fetch_asid` to equal the ASID held in control bits 15:8. When the enable is clear, the ASID is ignored.
- R5: In independent mode (MODE register bit 0 = 0), a hit on either channel raises `brk_req` in the same cycle as the flagged `fetch_valid` beat. `ch_match[i]` shows the raw hit of channel i.
- R6: In chained mode (MODE bit 0 = 1), a channel 0 fetch hit never breaks. Channel 1 breaks only once a `commit_valid` beat has matched channel 0's address and ASID conditions.
- R7: The armed state clears when channel 1 fires and on any write to register offsets 0 to 9. A settings write in the same cycle as an arming commit leaves the unit disarmed.
- R8: When channel 1's data enable (control bit 2) is set, a match also needs `fetch_data` to equal the data register in every bit whose data-mask bit is 0.
- R9: When channel 1's count enable (control bit 3) is set, a qualified hit with a nonzero count decrements it. The break fires only on a hit that finds the count at 1 or 0. A count of 0 breaks on the first hit and stays at 0.
- R10: A break sets `brk_status[i]` for the channel that fired, starting from the next cycle. Writing 1 to a bit at offset 10 clears it. If a fire and a clear hit the same bit in one cycle, the bit stays set.
- R11: Control bit 0 of each channel gates that channel. While it is clear, the channel's `ch_match` bit and its breaks stay 0.

Register offsets: 0 channel 0 control, 1 channel 0 address, 2 channel 0 mask, 3 channel 1 control, 4 channel 1 address, 5 channel 1 mask, 6 channel 1 data, 7 channel 1 data mask, 8 channel 1 count (load), 9 mode, 10 status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| fetch_valid | input | 1 | Fetch beat valid |
| fetch_addr | input | 32 | Fetch address |
| fetch_asid | input | 8 | Current address-space ID |
| fetch_data | input | 32 | Fetched instruction word |
| commit_valid | input | 1 | Instruction-commit beat valid |
| commit_addr | input | 32 | Address of committing instruction |
| commit_asid | input | 8 | ASID of committing instruction |
| ch_match | output | 2 | Raw per-channel fetch hit |
| brk_req | output | 1 | Break request, same cycle as flagged fetch |
| brk_status | output | 2 | Sticky per-channel break cause |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a status clear and a new break on the same channel. The bench writes 1 to the status offset in the very cycle a channel 0 fetch hit fires, then expects the bit to read 1 on the following cycle. The second pair is a settings write and an arming commit. The bench drives both beats together in chained mode and expects a later channel 1 hit to raise no break.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] OFS_C0_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] OFS_C0_ADDR  = 4'd1;
  localparam logic [REG_AW-1:0] OFS_C0_MASK  = 4'd2;
  localparam logic [REG_AW-1:0] OFS_C1_CTRL  = 4'd3;
  localparam logic [REG_AW-1:0] OFS_C1_ADDR  = 4'd4;
  localparam logic [REG_AW-1:0] OFS_C1_MASK  = 4'd5;
  localparam logic [REG_AW-1:0] OFS_C1_DATA  = 4'd6;
  localparam logic [REG_AW-1:0] OFS_C1_DMASK = 4'd7;
  localparam logic [REG_AW-1:0] OFS_C1_COUNT = 4'd8;
  localparam logic [REG_AW-1:0] OFS_MODE     = 4'd9;
  localparam logic [REG_AW-1:0] OFS_STATUS   = 4'd10;

  typedef enum logic {
    MODE_INDEP = 1'b0,
    MODE_CHAIN = 1'b1
  } brk_mode_e;
endpackage

// File: rtl/ibrk_cfg_regs.sv
module ibrk_cfg_regs
  import ibrk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter int NCH    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  output logic                 c0_en,
  output logic                 c0_asid_en,
  output logic [ASID_W-1:0]    c0_asid,
  output logic [ADDR_W-1:0]    c0_addr,
  output logic [ADDR_W-1:0]    c0_amask,
  output logic                 c1_en,
  output logic                 c1_asid_en,
  output logic                 c1_data_en,
  output logic                 c1_cnt_en,
  output logic [ASID_W-1:0]    c1_asid,
  output logic [ADDR_W-1:0]    c1_addr,
  output logic [ADDR_W-1:0]    c1_amask,
  output logic [DATA_W-1:0]    c1_data,
  output logic [DATA_W-1:0]    c1_dmask,
  output logic                 cnt_load,
  output logic [CNT_W-1:0]     cnt_value,
  output brk_mode_e            mode,
  output logic                 settings_wr,
  output logic [NCH-1:0]       stat_clr
);
  localparam int ASID_LO = 8;

  assign settings_wr = wr_en && (wr_addr <= OFS_MODE);
  assign cnt_load    = wr_en && (wr_addr == OFS_C1_COUNT);
  assign cnt_value   = wr_data[CNT_W-1:0];
  assign stat_clr    = (wr_en && (wr_addr == OFS_STATUS)) ? wr_data[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0_en <= 1'b0; c0_asid_en <= 1'b0; c0_asid <= '0;
      c0_addr <= '0; c0_amask <= '0;
      c1_en <= 1'b0; c1_asid_en <= 1'b0; c1_data_en <= 1'b0; c1_cnt_en <= 1'b0;
      c1_asid <= '0; c1_addr <= '0; c1_amask <= '0; c1_data <= '0; c1_dmask <= '0;
      mode <= MODE_INDEP;
    end else if (wr_en) begin
      case (wr_addr)
        OFS_C0_CTRL: begin
          c0_en      <= wr_data[0];
          c0_asid_en <= wr_data[1];
          c0_asid    <= wr_data[ASID_LO +: ASID_W];
        end
        OFS_C0_ADDR:  c0_addr  <= wr_data[ADDR_W-1:0];
        OFS_C0_MASK:  c0_amask <= wr_data[ADDR_W-1:0];
        OFS_C1_CTRL: begin
          c1_en      <= wr_data[0];
          c1_asid_en <= wr_data[1];
          c1_data_en <= wr_data[2];
          c1_cnt_en  <= wr_data[3];
          c1_asid    <= wr_data[ASID_LO +: ASID_W];
        end
        OFS_C1_ADDR:  c1_addr  <= wr_data[ADDR_W-1:0];
        OFS_C1_MASK:  c1_amask <= wr_data[ADDR_W-1:0];
        OFS_C1_DATA:  c1_data  <= wr_data[DATA_W-1:0];
        OFS_C1_DMASK: c1_dmask <= wr_data[DATA_W-1:0];
        OFS_MODE:     mode     <= brk_mode_e'(wr_data[0]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ibrk_match.sv
module ibrk_match #(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ASID_W-1:0] asid,
  input  logic [DATA_W-1:0] data,
  input  logic              en,
  input  logic              asid_en,
  input  logic              data_en,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [ADDR_W-1:0] cmp_amask,
  input  logic [ASID_W-1:0] cmp_asid,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic [DATA_W-1:0] cmp_dmask,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] LSB_ONLY = ADDR_W'(1);

  logic [ADDR_W-1:0] care_a;
  logic addr_ok, asid_ok, data_ok;

  // Bit 0 is never maskable: an odd compare address cannot meet an even fetch.
  assign care_a  = ~(cmp_amask & ~LSB_ONLY);
  assign addr_ok = (((addr ^ cmp_addr) & care_a) == '0);
  assign asid_ok = !asid_en || (asid == cmp_asid);
  assign data_ok = !data_en || (((data ^ cmp_data) & ~cmp_dmask) == '0);
  assign hit     = valid && en && addr_ok && asid_ok && data_ok;
endmodule

// File: rtl/ibrk_seq_ctrl.sv
module ibrk_seq_ctrl
  import ibrk_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int NCH   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  brk_mode_e        mode,
  input  logic             c0_fetch_hit,
  input  logic             c0_commit_hit,
  input  logic             c1_hit,
  input  logic             cnt_en,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_value,
  input  logic             settings_wr,
  input  logic [NCH-1:0]   stat_clr,
  output logic [NCH-1:0]   fire,
  output logic             brk_req,
  output logic [NCH-1:0]   status
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             chained, c1_qual, count_ok;

  assign chained  = (mode == MODE_CHAIN);
  assign c1_qual  = c1_hit && (!chained || armed_q);
  assign count_ok = !cnt_en || (cnt_q <= CNT_ONE);
  assign fire[0]  = c0_fetch_hit && !chained;
  assign fire[1]  = c1_qual && count_ok;
  assign brk_req  = |fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          armed_q <= 1'b0;
    else if (settings_wr)                armed_q <= 1'b0;
    else if (chained && c0_commit_hit)   armed_q <= 1'b1;
    else if (fire[1])                    armed_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      cnt_q <= '0;
    else if (cnt_load)                               cnt_q <= cnt_value;
    else if (c1_qual && cnt_en && (cnt_q != '0))     cnt_q <= cnt_q - CNT_ONE;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_stat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           status[i] <= 1'b0;
      else if (fire[i])     status[i] <= 1'b1;
      else if (stat_clr[i]) status[i] <= 1'b0;
    end

    p_status_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[i]) |-> $past(fire[i]));
  end

  p_arm_from_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(c0_commit_hit && chained));

  p_settings_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    settings_wr |=> !armed_q);

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_qual && cnt_en && (cnt_q > CNT_ONE) && !cnt_load) |=> (cnt_q == $past(cnt_q) - CNT_ONE));
endmodule

// File: rtl/ifetch_break_unit.sv
module ifetch_break_unit
  import ibrk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [3:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [ASID_W-1:0] fetch_asid,
  input  logic [DATA_W-1:0] fetch_data,
  input  logic              commit_valid,
  input  logic [ADDR_W-1:0] commit_addr,
  input  logic [ASID_W-1:0] commit_asid,
  output logic [1:0]        ch_match,
  output logic              brk_req,
  output logic [1:0]        brk_status
);
  localparam int NCH = 2;

  logic              c0_en, c0_asid_en, c1_en, c1_asid_en, c1_data_en, c1_cnt_en;
  logic [ASID_W-1:0] c0_asid, c1_asid;
  logic [ADDR_W-1:0] c0_addr, c0_amask, c1_addr, c1_amask;
  logic [DATA_W-1:0] c1_data, c1_dmask;
  logic              cnt_load, settings_wr;
  logic [CNT_W-1:0]  cnt_value;
  brk_mode_e         mode;
  logic [NCH-1:0]    stat_clr, fire;
  logic              c0_fetch_hit, c0_commit_hit, c1_hit;

  ibrk_cfg_regs #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .DATA_W(DATA_W),
                  .CNT_W(CNT_W), .NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .c0_en(c0_en), .c0_asid_en(c0_asid_en), .c0_asid(c0_asid), .c0_addr(c0_addr),
    .c0_amask(c0_amask), .c1_en(c1_en), .c1_asid_en(c1_asid_en), .c1_data_en(c1_data_en),
    .c1_cnt_en(c1_cnt_en), .c1_asid(c1_asid), .c1_addr(c1_addr), .c1_amask(c1_amask),
    .c1_data(c1_data), .c1_dmask(c1_dmask), .cnt_load(cnt_load), .cnt_value(cnt_value),
    .mode(mode), .settings_wr(settings_wr), .stat_clr(stat_clr)
  );

  ibrk_match #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .DATA_W(DATA_W)) u_c0_fetch (
    .valid(fetch_valid), .addr(fetch_addr), .asid(fetch_asid), .data(fetch_data),
    .en(c0_en), .asid_en(c0_asid_en), .data_en(1'b0), .cmp_addr(c0_addr),
    .cmp_amask(c0_amask), .cmp_asid(c0_asid), .cmp_data('0), .cmp_dmask('0),
    .hit(c0_fetch_hit)
  );

  ibrk_match #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .DATA_W(DATA_W)) u_c0_commit (
    .valid(commit_valid), .addr(commit_addr), .asid(commit_asid), .data('0),
    .en(c0_en), .asid_en(c0_asid_en), .data_en(1'b0), .cmp_addr(c0_addr),
    .cmp_amask(c0_amask), .cmp_asid(c0_asid), .cmp_data('0), .cmp_dmask('0),
    .hit(c0_commit_hit)
  );

  ibrk_match #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .DATA_W(DATA_W)) u_c1_fetch (
    .valid(fetch_valid), .addr(fetch_addr), .asid(fetch_asid), .data(fetch_data),
    .en(c1_en), .asid_en(c1_asid_en), .data_en(c1_data_en), .cmp_addr(c1_addr),
    .cmp_amask(c1_amask), .cmp_asid(c1_asid), .cmp_data(c1_data), .cmp_dmask(c1_dmask),
    .hit(c1_hit)
  );

  ibrk_seq_ctrl #(.CNT_W(CNT_W), .NCH(NCH)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .c0_fetch_hit(c0_fetch_hit),
    .c0_commit_hit(c0_commit_hit), .c1_hit(c1_hit), .cnt_en(c1_cnt_en),
    .cnt_load(cnt_load), .cnt_value(cnt_value), .settings_wr(settings_wr),
    .stat_clr(stat_clr), .fire(fire), .brk_req(brk_req), .status(brk_status)
  );

  assign ch_match = {c1_hit, c0_fetch_hit};

  p_brk_on_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> fetch_valid);

  p_gate_c0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ch_match[0] |-> c0_en);

  p_gate_c1_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ch_match[1] |-> c1_en);
endmodule

// File: tb/tb_ifetch_break_unit.sv
module tb_ifetch_break_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {addr[74:43], asid[42:35], data[34:3], match[2:1], brk[0]}
  localparam logic [74:0] VEC [NVEC] = '{
    {32'h0002_7128, 8'h00, 32'h0000_0000, 2'b01, 1'b1},
    {32'h0002_712A, 8'h00, 32'h0000_0000, 2'b00, 1'b0},
    {32'h0003_722E, 8'h70, 32'hCAFE_1234, 2'b10, 1'b1},
    {32'h0003_72EE, 8'h70, 32'hCAFE_0000, 2'b10, 1'b1},
    {32'h0003_732E, 8'h70, 32'hCAFE_0000, 2'b00, 1'b0},
    {32'h0003_722E, 8'h71, 32'hCAFE_0000, 2'b00, 1'b0},
    {32'h0003_722E, 8'h70, 32'hCAFF_0000, 2'b00, 1'b0},
    {32'h0002_7128, 8'h55, 32'h0000_0000, 2'b01, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic [7:0]  fetch_asid = '0;
  logic [31:0] fetch_data = '0;
  logic        commit_valid = 1'b0;
  logic [31:0] commit_addr = '0;
  logic [7:0]  commit_asid = '0;
  logic [1:0]  ch_match;
  logic        brk_req;
  logic [1:0]  brk_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifetch_break_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_asid(fetch_asid), .fetch_data(fetch_data), .commit_valid(commit_valid),
    .commit_addr(commit_addr), .commit_asid(commit_asid), .ch_match(ch_match),
    .brk_req(brk_req), .brk_status(brk_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet();
    @(negedge clk);
    fetch_valid = 1'b0; commit_valid = 1'b0; cfg_wr_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    fetch_valid = 1'b0; commit_valid = 1'b0;
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic do_fetch(input logic [31:0] a, input logic [7:0] s, input logic [31:0] d);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a; fetch_asid = s; fetch_data = d;
    #1;
  endtask

  task automatic do_commit(input logic [31:0] a, input logic [7:0] s);
    @(negedge clk);
    fetch_valid = 1'b0; commit_valid = 1'b1; commit_addr = a; commit_asid = s;
    @(negedge clk);
    commit_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 status", 32'(brk_status), 32'h0);
    do_fetch(32'h0, 8'h0, 32'h0);
    chk("R1 match", 32'(ch_match), 32'h0);
    chk("R1 brk", 32'(brk_req), 32'h0);
    quiet();

    // Table: independent mode, R2 R4 R5 R8
    wr(4'd1, 32'h0002_7128); wr(4'd2, 32'h0); wr(4'd0, 32'h0000_0001);
    wr(4'd4, 32'h0003_722E); wr(4'd5, 32'h0000_00F0);
    wr(4'd6, 32'hCAFE_0000); wr(4'd7, 32'h0000_FFFF);
    wr(4'd3, 32'h0000_7007);
    for (int i = 0; i < NVEC; i++) begin
      do_fetch(VEC[i][74:43], VEC[i][42:35], VEC[i][34:3]);
      chk($sformatf("R2/R4/R8 vec%0d match", i), 32'(ch_match), 32'(VEC[i][2:1]));
      chk($sformatf("R5 vec%0d brk", i), 32'(brk_req), 32'(VEC[i][0]));
    end
    quiet();
    chk("R10 status both set", 32'(brk_status), 32'h3);
    wr(4'd10, 32'h3);
    chk("R10 w1c", 32'(brk_status), 32'h0);

    // R11: disabled channel
    wr(4'd0, 32'h0);
    do_fetch(32'h0002_7128, 8'h0, 32'h0);
    chk("R11 disabled match", 32'(ch_match), 32'h0);
    chk("R11 disabled brk", 32'(brk_req), 32'h0);
    quiet();

    // R3: odd compare address, even with mask bit 0 set
    wr(4'd1, 32'h0003_1415); wr(4'd2, 32'h1); wr(4'd0, 32'h1);
    do_fetch(32'h0003_1414, 8'h0, 32'h0);
    chk("R3 odd masked", 32'(ch_match), 32'h0);
    quiet();
    wr(4'd2, 32'h0);
    do_fetch(32'h0003_1414, 8'h0, 32'h0);
    chk("R3 odd exact", 32'(brk_req), 32'h0);
    quiet();

    // R6 / R7: chained mode
    wr(4'd1, 32'h0003_7226); wr(4'd0, 32'h0000_8003);
    wr(4'd4, 32'h0003_722E); wr(4'd5, 32'h0); wr(4'd3, 32'h0000_7003);
    wr(4'd9, 32'h1);
    do_fetch(32'h0003_7226, 8'h80, 32'h0);
    chk("R6 c0 hit seen", 32'(ch_match), 32'h1);
    chk("R6 c0 no brk", 32'(brk_req), 32'h0);
    do_fetch(32'h0003_722E, 8'h70, 32'h0);
    chk("R6 c1 before arm", 32'(brk_req), 32'h0);
    quiet();
    do_commit(32'h0003_7226, 8'h81);
    do_fetch(32'h0003_722E, 8'h70, 32'h0);
    chk("R6 wrong commit asid", 32'(brk_req), 32'h0);
    quiet();
    do_commit(32'h0003_7226, 8'h80);
    do_fetch(32'h0003_722E, 8'h70, 32'h0);
    chk("R6 armed brk", 32'(brk_req), 32'h1);
    do_fetch(32'h0003_722E, 8'h70, 32'h0);
    chk("R7 disarm after fire", 32'(brk_req), 32'h0);
    quiet();
    do_commit(32'h0003_7226, 8'h80);
    wr(4'd9, 32'h1);
    do_fetch(32'h0003_722E, 8'h70, 32'h0);
    chk("R7 settings write disarms", 32'(brk_req), 32'h0);
    quiet();
    // R7: write and arming commit in the same cycle
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = 4'd9; cfg_wdata = 32'h1;
    commit_valid = 1'b1; commit_addr = 32'h0003_7226; commit_asid = 8'h80;
    quiet();
    do_fetch(32'h0003_722E, 8'h70, 32'h0);
    chk("R7 write beats arm", 32'(brk_req), 32'h0);
    quiet();

    // R9: execution count, independent mode
    wr(4'd9, 32'h0); wr(4'd3, 32'h0000_700B); wr(4'd8, 32'd2);
    do_fetch(32'h0003_722E, 8'h70, 32'h0);
    chk("R9 count hit1", 32'(brk_req), 32'h0);
    do_fetch(32'h0003_722E, 8'h70, 32'h0);
    chk("R9 count hit2", 32'(brk_req), 32'h1);
    do_fetch(32'h0003_722E, 8'h70, 32'h0);
    chk("R9 count stays 0", 32'(brk_req), 32'h1);
    quiet();
    wr(4'd8, 32'd0);
    do_fetch(32'h0003_722E, 8'h70, 32'h0);
    chk("R9 count zero first", 32'(brk_req), 32'h1);
    quiet();

    // R10: clear and fire in the same cycle on channel 0
    wr(4'd10, 32'h3);
    wr(4'd1, 32'h0002_7128); wr(4'd0, 32'h1);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = 4'd10; cfg_wdata = 32'h1;
    fetch_valid = 1'b1; fetch_addr = 32'h0002_7128; fetch_asid = 8'h0;
    quiet();
    chk("R10 set beats clear", 32'(brk_status), 32'h1);

    finish_run();
  end
endmodule